// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block turns bytes handed over by a host into asynchronous serial character frames. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and 1, 1.5 or 2 high stop bits. The frame format comes from a 7-bit line-control input. A one-cycle `tick` pulse paces the block at sixteen pulses per bit time, so a bit lasts 16 ticks. The divisor that makes `tick` is outside this block.

Bytes enter through a valid/ready port. The port fronts a one-entry holding register. `in_ready` is high exactly when the holding register is empty, so it also serves as the holding-empty status flag. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. After that, `in_ready` stays low until the byte moves into the shift register. A host that sees `in_ready` low keeps `in_valid` and `in_data` steady and waits; no byte is dropped or overwritten. The holding register hands its byte to the shift register on the edge where the shifter goes idle, or at once if it is already idle. This lets frames follow one another with no gap.

A loopback input keeps the external line idle and sends the frame to an internal receiver path instead. A break control holds the line low for as long as it is set.

Top module: `uart_tx`

## Requirements
- R1: After reset, `txd` and `loop_rxd` are high, and `in_ready` and `tx_empty` are high.
- R2: `line_ctrl[1:0]` selects the word length (00=5, 01=6, 10=7, 11=8 data bits). A frame starts with one low start bit, and data goes out least significant bit first. Data bits above the selected length are not sent.
- R3: When `line_ctrl[2]` is 0, a frame has one stop bit (16 ticks). When it is 1, a 5-bit word gets 1.5 stop bits (24 ticks), and 6-, 7- and 8-bit words get 2 stop bits (32 ticks). Stop bits are high.
- R4: When `line_ctrl[3]` is 1, one parity bit follows the last data bit. With `line_ctrl[4]`=1 the parity is even (the parity bit is the XOR of the sent data bits). With `line_ctrl[4]`=0 it is odd (the inverse of that XOR).
- R5: When `line_ctrl[5]` (stick) and `line_ctrl[3]` are both 1, the parity bit is a constant: low if `line_ctrl[4]`=1, high if `line_ctrl[4]`=0.
- R6: While `line_ctrl[6]` (break) is 1, the serial line is low. When it clears, the line goes back to the value it would otherwise carry.
- R7: Every bit, including the start bit, lasts exactly 16 `tick` pulses. With no tick, the line holds its value.
- R8: `in_ready` is high only when the holding register is empty. It goes low the cycle after an accepted transfer and stays low until the byte moves to the shift register.
- R9: `tx_empty` is high only when both the holding register and the shift register are empty.
- R10: A byte waiting in the holding register starts its start bit on the same edge on which the previous frame's last stop bit ends. The distance from one start to the next is exactly one frame length in ticks.
- R11: When `loopback` is 1, `txd` is held high and the frame appears on `loop_rxd`. When `loopback` is 0, `loop_rxd` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable, 16 pulses per bit |
| line_ctrl | input | 7 | Frame format, stick parity and break controls |
| loopback | input | 1 | Route the frame internally and hold `txd` high |
| in_valid | input | 1 | Host byte valid |
| in_data | input | DATA_W | Host byte |
| in_ready | output | 1 | Holding register empty; byte accepted when high with `in_valid` |
| txd | output | 1 | External serial line |
| loop_rxd | output | 1 | Internal loopback line toward a receiver |
| tx_empty | output | 1 | Holding and shift registers both empty |

## Verification
Two functions can fall on the same clock edge: the end of a frame's last stop bit and the move of a waiting byte from the holding register into the shifter. The bench provokes this by pushing a second byte while the first frame is in progress. It covers all 64 combinations of word length, stop, parity, even and stick bits. It then measures the tick distance between the two start edges and compares it with the frame length it computes arithmetically, so a lost or extra idle cycle or a wrong stop length shows up as a mismatch. Every bit of both frames is sampled at its mid-point, and during the first frame the bench checks that the second byte is held (`in_ready` and `tx_empty` low).

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int LC_W     = 7;
  localparam int WORD_MIN = 5;

  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] wlen;
  } frame_cfg_t;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          take,
  output logic [DW-1:0] hold_data,
  output logic          hold_full
);
  logic accept;

  assign in_ready = ~hold_full;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (take) begin
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_data <= in_data;
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  frame_cfg_t    cfg,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          frame_end,
  output logic          ser
);
  localparam int FW   = DW + 4;
  localparam int SUBW = $clog2(OVS);
  localparam int CW   = $clog2(OVS * FW + 1);

  logic [FW-1:0] sh, frame_n;
  logic [CW-1:0] cnt, len, len_n;
  logic          par_acc, par_bit;
  int            nb, stop_t;

  always_comb begin
    nb      = WORD_MIN + int'(cfg.wlen);
    frame_n = '1;
    frame_n[0] = 1'b0;
    par_acc = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < nb) begin
        frame_n[1+i] = data[i];
        par_acc      = par_acc ^ data[i];
      end
    end
    if (cfg.stick) par_bit = ~cfg.even;
    else           par_bit = cfg.even ? par_acc : ~par_acc;
    for (int j = 0; j < FW; j++) begin
      if (cfg.par_en && (j == nb + 1)) frame_n[j] = par_bit;
    end
    if (!cfg.long_stop)      stop_t = OVS;
    else if (cfg.wlen == 0)  stop_t = OVS + OVS / 2;
    else                     stop_t = 2 * OVS;
    len_n = CW'(OVS * (1 + nb + int'(cfg.par_en)) + stop_t);
  end

  assign frame_end = busy & tick & (cnt == (len - CW'(1)));
  assign ser       = sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      cnt  <= '0;
      len  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= frame_n;
      cnt  <= '0;
      len  <= len_n;
      busy <= 1'b1;
    end else if (frame_end) begin
      sh   <= '1;
      busy <= 1'b0;
    end else if (busy && tick) begin
      cnt <= cnt + CW'(1);
      if (cnt[SUBW-1:0] == SUBW'(OVS - 1)) sh <= {1'b1, sh[FW-1:1]};
    end
  end
endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line (
  input  logic ser,
  input  logic brk,
  input  logic loopback,
  output logic txd,
  output logic loop_rxd
);
  logic line;

  assign line     = ser & ~brk;
  assign txd      = loopback ? 1'b1 : line;
  assign loop_rxd = loopback ? line : 1'b1;
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_tx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [LC_W-1:0]   line_ctrl,
  input  logic              loopback,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic              loop_rxd,
  output logic              tx_empty
);
  frame_cfg_t        fcfg;
  logic              brk, hold_full, busy, frame_end, load, ser;
  logic [DATA_W-1:0] hold_data;

  assign fcfg     = frame_cfg_t'(line_ctrl[5:0]);
  assign brk      = line_ctrl[6];
  assign load     = hold_full & (~busy | frame_end);
  assign tx_empty = ~hold_full & ~busy;

  uart_tx_hold #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .take(load), .hold_data(hold_data),
    .hold_full(hold_full)
  );

  uart_tx_shift #(.OVS(OVS), .DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .cfg(fcfg),
    .data(hold_data), .busy(busy), .frame_end(frame_end), .ser(ser)
  );

  uart_tx_line u_line (
    .ser(ser), .brk(brk), .loopback(loopback), .txd(txd),
    .loop_rxd(loop_rxd)
  );
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [6:0] line_ctrl,
  input logic       loopback,
  input logic       in_valid,
  input logic       in_ready,
  input logic       txd,
  input logic       loop_rxd,
  input logic       tx_empty
);
  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R8
  AST_EMPTY_MEANS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> in_ready); // R9
  AST_LOOP_TXD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> txd); // R11
  AST_LOOP_RXD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !loopback |-> loop_rxd); // R11
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    line_ctrl[6] && !loopback |-> !txd); // R6
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty && !line_ctrl[6] && !loopback |-> txd); // R1
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && in_ready && !in_valid && !tx_empty) ##1
    ($stable(line_ctrl) && $stable(loopback)) |-> $stable(txd)); // R7
endmodule

bind uart_tx uart_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .line_ctrl(line_ctrl),
  .loopback(loopback), .in_valid(in_valid), .in_ready(in_ready),
  .txd(txd), .loop_rxd(loop_rxd), .tx_empty(tx_empty)
);

// File: tb/tb_uart_tx.sv
module tb_uart_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] line_ctrl = '0;
  logic       loopback = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, txd, loop_rxd, tx_empty;

  int  checks = 0, errors = 0, cyc = 0, tick_total = 0;
  bit  tick_en = 1'b1, phase = 1'b0, mon_loop = 1'b0;
  logic line, other;

  assign line  = mon_loop ? loop_rxd : txd;
  assign other = mon_loop ? txd : loop_rxd;

  uart_tx dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_ctrl(line_ctrl),
    .loopback(loopback), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd), .loop_rxd(loop_rxd), .tx_empty(tx_empty)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    phase <= ~phase;
    tick  <= tick_en & phase;
  end

  always @(posedge clk) begin
    if (rst_n && tick) tick_total++;
    cyc++;
    if (cyc >= 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int k, input logic [6:0] lc,
                                   input logic [7:0] d);
    int n = 5 + int'(lc[1:0]);
    logic p = 1'b0;
    if (k == 0) return 1'b0;
    if (k <= n) return d[k-1];
    if (lc[3] && k == n + 1) begin
      for (int i = 0; i < n; i++) p ^= d[i];
      if (lc[5]) return ~lc[4];
      return lc[4] ? p : ~p;
    end
    return 1'b1;
  endfunction

  function automatic int frame_len(input logic [6:0] lc);
    int n = 5 + int'(lc[1:0]);
    int st = !lc[2] ? 16 : (n == 5 ? 24 : 32);
    return 16 * (1 + n + int'(lc[3])) + st;
  endfunction

  task automatic push(input logic [7:0] d);
    forever begin
      @(negedge clk);
      if (in_ready) begin
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R8", "ready after accept", in_ready, 0);
        break;
      end
    end
  endtask

  task automatic wait_fall(output int t);
    logic prev = line;
    forever begin
      @(negedge clk);
      if (prev && !line) break;
      prev = line;
    end
    t = tick_total;
  endtask

  task automatic check_frame(input int t0, input logic [6:0] lc,
                             input logic [7:0] d, input bit first);
    int  n  = 5 + int'(lc[1:0]);
    int  nb = 1 + n + int'(lc[3]);
    logic e;
    for (int k = 0; k <= nb; k++) begin
      while (tick_total - t0 < 16 * k + 8) @(negedge clk);
      e = exp_bit(k, lc, d);
      if (k == 0 || (k >= 1 && k <= n))
        chk(line == e, "R2", $sformatf("lc=%0h bit%0d", lc, k), line, e);
      else if (k == n + 1 && lc[3])
        chk(line == e, lc[5] ? "R5" : "R4", $sformatf("lc=%0h parity", lc), line, e);
      else
        chk(line == 1'b1, "R3", $sformatf("lc=%0h stop", lc), line, 1);
      chk(other == 1'b1, "R11", "unused path idle", other, 1);
      if (first && k == 1) begin
        chk(in_ready == 1'b0, "R8", "second byte held", in_ready, 0);
        chk(tx_empty == 1'b0, "R9", "busy not empty", tx_empty, 0);
      end
    end
  endtask

  task automatic run_pair(input logic [6:0] lc, input logic [7:0] d0,
                          input logic [7:0] d1, input bit lp);
    int ta, tb;
    @(negedge clk);
    line_ctrl = lc;
    loopback  = lp;
    mon_loop  = lp;
    fork
      begin
        push(d0);
        push(d1);
      end
      begin
        wait_fall(ta);
        check_frame(ta, lc, d0, 1'b1);
        wait_fall(tb);
        chk(tb - ta == frame_len(lc), "R3/R10", $sformatf("lc=%0h start gap", lc),
            tb - ta, frame_len(lc));
        check_frame(tb, lc, d1, 1'b0);
      end
    join
    while (!tx_empty) @(negedge clk);
    @(negedge clk);
    chk(tx_empty && in_ready, "R9", "empty after frames", tx_empty, 1);
    chk(line == 1'b1, "R9", "line idle after frames", line, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd in reset", txd, 1);
    chk(loop_rxd == 1'b1, "R1", "loop_rxd in reset", loop_rxd, 1);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    chk(tx_empty == 1'b1, "R1", "tx_empty in reset", tx_empty, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 break forces the line low, clearing returns it high
    line_ctrl = 7'h43;
    @(negedge clk);
    chk(txd == 1'b0, "R6", "break low", txd, 0);
    line_ctrl = 7'h03;
    @(negedge clk);
    chk(txd == 1'b1, "R6", "break cleared", txd, 1);

    // R7 no ticks: start bit holds, byte already in shifter
    tick_en = 1'b0;
    push(8'h55);
    repeat (40) @(negedge clk);
    chk(txd == 1'b0, "R7", "start held without tick", txd, 0);
    chk(tx_empty == 1'b0, "R7", "busy without tick", tx_empty, 0);
    chk(in_ready == 1'b1, "R8", "holding freed after move", in_ready, 1);
    tick_en = 1'b1;
    while (!tx_empty) @(negedge clk);
    @(negedge clk);
    chk(txd == 1'b1, "R7", "idle after resumed frame", txd, 1);

    // Full sweep of format bits, back-to-back frames
    for (int c = 0; c < 64; c++) begin
      logic [7:0] d0 = 8'(c * 37 + 11) ^ 8'hA0;
      logic [7:0] d1 = ~d0 ^ 8'(c);
      run_pair({1'b0, 6'(c)}, d0, d1, 1'b0);
    end

    // R11 loopback frames
    run_pair(7'h03, 8'hC5, 8'h3A, 1'b1);
    run_pair(7'h0F, 8'h81, 8'h7E, 1'b1);
    run_pair(7'h2C, 8'hF0, 8'h0F, 1'b1);

    loopback = 1'b0;
    mon_loop = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule